// File: doc/BRIEF.md
# Data-Move Instruction Execution Unit

This block carries out the register and memory move subset of a 16-bit fixed-length instruction set. It holds sixteen general registers of `W` bits. It accepts one opcode at a time, together with that opcode's instruction address, over a valid/ready handshake. When the opcode needs memory, the unit raises a single memory request and holds it until a response arrives. When the operation finishes it writes the destination register and, where the addressing form calls for it, the address register.

The addressing forms are:

- an 8-bit immediate;
- a register copy;
- register-indirect loads and stores;
- pre-decrement stores and post-increment loads;
- register plus a scaled 4-bit displacement (byte and word forms always use R0 as the data register);
- a byte store indexed by R0;
- word and long loads relative to the instruction address.

Any opcode outside this subset completes without effect and raises an illegal flag.

The unit is not pipelined. It processes one operation at a time. The only state visible outside it is what it presents on the memory port, so register contents are observed by storing them.

Top module: `dm_exec`

## Requirements
- R1: `op_ready` is high only while the unit is idle, and an opcode is taken on a clock edge where `op_valid` and `op_ready` are both high. An opcode with no memory access completes in the first cycle after acceptance. Completion is marked by a one-cycle `op_done`, and the unit is ready again in the next cycle. `op_valid` is ignored while the unit is busy.
- R2: Pattern `1110nnnniiiiiiii` writes the 8-bit immediate, sign-extended, into Rn without a memory request.
- R3: Pattern `0110nnnnmmmm0011` copies all bits of Rm into Rn without a memory request.
- R4: Stores to the address in Rn (`0010nnnnmmmm00ss`) and loads from the address in Rm (`0110nnnnmmmm00ss`) use `mem_size` = ss, where 00 is byte, 01 is word and 10 is long. A store drives the whole of Rm on `mem_wdata`. A load takes its data from the low bits of `mem_rdata`. Byte and word loads are sign-extended; long loads are passed through unchanged.
- R5: Pre-decrement stores (`0010nnnnmmmm01ss`) lower Rn by 1, 2 or 4 according to size, write Rm to the lowered address, and leave Rn holding that address. If Rm and Rn are the same register, the stored data is the value before the decrement.
- R6: Post-increment loads (`0110nnnnmmmm01ss`) read from Rm, load the (extended) data into Rn, and raise Rm by 1, 2 or 4. When Rm equals Rn, the loaded data is kept and the increment is lost.
- R7: Byte and word displacement forms `10000000nnnndddd` / `10000001nnnndddd` (store R0) and `10000100mmmmdddd` / `10000101mmmmdddd` (load into R0) use address base + d×1 or base + d×2.
- R8: Long displacement forms `0001nnnnmmmmdddd` (store Rm to Rn + d×4) and `0101nnnnmmmmdddd` (load Rn from Rm + d×4) use any register pair.
- R9: `0000nnnnmmmm0100` stores the low byte of Rm at address R0 + Rn.
- R10: `1001nnnndddddddd` loads a sign-extended word from (PC+4) + d×2. `1101nnnndddddddd` loads a long from ((PC+4) with its two low bits cleared) + d×4.
- R11: Any other opcode raises `op_illegal` together with `op_done` in the first cycle after acceptance, issues no memory request, and changes no register.
- R12: While a request waits for `mem_rsp`, `mem_req`, `mem_addr`, `mem_size` and `mem_we` stay constant. All register writes take effect on the edge where `mem_rsp` is high.
- R13: Reset clears every register to zero, leaves the unit ready, and deasserts `mem_req` and `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit idle, opcode will be taken |
| op_code | input | 16 | Instruction opcode |
| op_pc | input | 32 (W) | Address of the instruction |
| op_done | output | 1 | One-cycle completion marker |
| op_illegal | output | 1 | Completed opcode was outside the subset |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | 00 byte, 01 word, 10 long |
| mem_addr | output | 32 (W) | Byte address of the request |
| mem_wdata | output | 32 (W) | Store data, whole source register |
| mem_rsp | input | 1 | Memory response for the pending request |
| mem_rdata | input | 32 (W) | Load data, right-aligned |

## Verification
A program of opcodes runs against a zero-filled register file. It first plants sign-sensitive immediates and loaded values such as 0x90, 0x7FFE and 0x8001. Each value is then read back through a later store, so a wrong extension width, a wrong displacement scale or an update of the wrong register all show up as a different store address or store data. Coinciding register numbers are tested in a pre-decrement store and in a post-increment load to tell which write wins. Instruction addresses that are aligned, odd and two above a word boundary separate the long-form alignment from the word form. Response latencies from zero to three cycles, with a new opcode offered while the unit is busy, confirm that the request holds still and that nothing extra is taken in.

// File: rtl/dm_pkg.sv
package dm_pkg;
   localparam int OPC_W  = 16;
   localparam int RIDX_W = 4;

   typedef enum logic [1:0] {SZ_B = 2'b00, SZ_W = 2'b01, SZ_L = 2'b10} size_e;
   typedef enum logic [1:0] {WS_IMM, WS_REG, WS_MEM} wsrc_e;
   typedef enum logic [1:0] {UP_NONE, UP_PRE, UP_POST} upd_e;

   typedef struct packed {
      logic              legal;
      logic              mem;
      logic              store;
      size_e             size;
      logic              wr_rd;
      logic [RIDX_W-1:0] rd;
      wsrc_e             wsrc;
      logic [RIDX_W-1:0] rs;
      logic [RIDX_W-1:0] rb;
      logic              use_pc;
      logic              use_idx;
      upd_e              upd;
      logic [9:0]        ofs;
      logic [7:0]        imm;
   } dec_t;
endpackage

// File: rtl/dm_decode.sv
module dm_decode
   import dm_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   logic [3:0] f_hi, f_n, f_m, f_lo;
   logic [7:0] f_d8;

   assign f_hi = opc[15:12];
   assign f_n  = opc[11:8];
   assign f_m  = opc[7:4];
   assign f_lo = opc[3:0];
   assign f_d8 = opc[7:0];

   always_comb begin
      dec      = '0;
      dec.size = SZ_L;
      case (f_hi)
         4'hE: begin
            dec.legal = 1'b1; dec.wr_rd = 1'b1; dec.rd = f_n;
            dec.wsrc  = WS_IMM; dec.imm = f_d8;
         end
         4'h9, 4'hD: begin
            dec.legal  = 1'b1; dec.mem = 1'b1; dec.use_pc = 1'b1;
            dec.wr_rd  = 1'b1; dec.rd  = f_n;  dec.wsrc   = WS_MEM;
            dec.size   = f_hi[2] ? SZ_L : SZ_W;
            dec.ofs    = f_hi[2] ? {f_d8, 2'b00} : {1'b0, f_d8, 1'b0};
         end
         4'h6: begin
            dec.rd = f_n; dec.wr_rd = 1'b1;
            if (f_lo == 4'b0011) begin
               dec.legal = 1'b1; dec.wsrc = WS_REG; dec.rs = f_m;
            end else if (!f_lo[3] && f_lo[1:0] != 2'b11) begin
               dec.legal = 1'b1; dec.mem = 1'b1; dec.wsrc = WS_MEM;
               dec.rb    = f_m;  dec.size = size_e'(f_lo[1:0]);
               dec.upd   = f_lo[2] ? UP_POST : UP_NONE;
            end
         end
         4'h2: begin
            if (!f_lo[3] && f_lo[1:0] != 2'b11) begin
               dec.legal = 1'b1; dec.mem = 1'b1; dec.store = 1'b1;
               dec.rs    = f_m;  dec.rb  = f_n;  dec.size  = size_e'(f_lo[1:0]);
               dec.upd   = f_lo[2] ? UP_PRE : UP_NONE;
            end
         end
         4'h8: begin
            if (f_n[3:1] == 3'b000 || f_n[3:1] == 3'b010) begin
               dec.legal = 1'b1; dec.mem = 1'b1;
               dec.size  = size_e'({1'b0, f_n[0]});
               dec.rb    = f_m;
               dec.ofs   = 10'(f_lo) << f_n[0];
               if (f_n[2]) begin
                  dec.wr_rd = 1'b1; dec.rd = '0; dec.wsrc = WS_MEM;
               end else begin
                  dec.store = 1'b1; dec.rs = '0;
               end
            end
         end
         4'h1: begin
            dec.legal = 1'b1; dec.mem = 1'b1; dec.store = 1'b1;
            dec.rs = f_m; dec.rb = f_n; dec.ofs = {4'b0, f_lo, 2'b00};
         end
         4'h5: begin
            dec.legal = 1'b1; dec.mem = 1'b1; dec.wr_rd = 1'b1; dec.wsrc = WS_MEM;
            dec.rd = f_n; dec.rb = f_m; dec.ofs = {4'b0, f_lo, 2'b00};
         end
         4'h0: begin
            if (f_lo == 4'b0100) begin
               dec.legal = 1'b1; dec.mem = 1'b1; dec.store = 1'b1; dec.size = SZ_B;
               dec.rs = f_m; dec.rb = f_n; dec.use_idx = 1'b1;
            end
         end
         default: dec = dec;
      endcase
   end
endmodule

// File: rtl/dm_agen.sv
module dm_agen
   import dm_pkg::*;
#(
   parameter int W       = 32,
   parameter int PC_STEP = 4
) (
   input  dec_t         dec,
   input  logic [W-1:0] pc,
   input  logic [W-1:0] base_reg,
   input  logic [W-1:0] idx_reg,
   output logic [W-1:0] addr,
   output logic [W-1:0] upd_val
);
   localparam logic [W-1:0] PC_ADV = W'(PC_STEP);

   logic [W-1:0] pc_base, base, step, idx;

   always_comb begin
      pc_base = pc + PC_ADV;
      if (dec.size == SZ_L) pc_base[1:0] = 2'b00;
      base = dec.use_pc  ? pc_base : base_reg;
      idx  = dec.use_idx ? idx_reg : '0;
      step = W'(1) << dec.size;
      if (dec.upd == UP_PRE) addr = base - step;
      else                   addr = base + W'(dec.ofs) + idx;
      upd_val = (dec.upd == UP_PRE) ? addr : base + step;
   end
endmodule

// File: rtl/dm_regfile.sv
module dm_regfile #(
   parameter int W     = 32,
   parameter int NREG  = 16,
   parameter bit CLEAR = 1'b1,
   localparam int IW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wa_en,
   input  logic [IW-1:0] wa_idx,
   input  logic [W-1:0]  wa_dat,
   input  logic          wb_en,
   input  logic [IW-1:0] wb_idx,
   input  logic [W-1:0]  wb_dat,
   input  logic [IW-1:0] ra_idx,
   output logic [W-1:0]  ra_dat,
   input  logic [IW-1:0] rb_idx,
   output logic [W-1:0]  rb_dat,
   output logic [W-1:0]  r0_dat
);
   logic [W-1:0] rf [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic         hit_a, hit_b;
      logic [W-1:0] q;
      assign hit_a = wa_en && (wa_idx == IW'(g));
      assign hit_b = wb_en && (wb_idx == IW'(g));
      if (CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (hit_a || hit_b)   q <= hit_a ? wa_dat : wb_dat;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit_a || hit_b) q <= hit_a ? wa_dat : wb_dat;
         end
      end
      assign rf[g] = q;
   end

   assign ra_dat = rf[ra_idx];
   assign rb_dat = rf[rb_idx];
   assign r0_dat = rf[0];
endmodule

// File: rtl/dm_exec.sv
module dm_exec
   import dm_pkg::*;
#(
   parameter int W          = 32,
   parameter int NREG       = 16,
   parameter int PC_STEP    = 4,
   parameter bit CLEAR_REGS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic [OPC_W-1:0] op_code,
   input  logic [W-1:0]     op_pc,
   output logic             op_done,
   output logic             op_illegal,
   output logic             mem_req,
   output logic             mem_we,
   output logic [1:0]       mem_size,
   output logic [W-1:0]     mem_addr,
   output logic [W-1:0]     mem_wdata,
   input  logic             mem_rsp,
   input  logic [W-1:0]     mem_rdata
);
   if (W < 32) begin : g_bad_width
      $error("dm_exec: W must be at least 32");
   end
   if (NREG != 2**RIDX_W) begin : g_bad_nreg
      $error("dm_exec: NREG must match the 4-bit register fields");
   end

   logic             busy, finish;
   logic [OPC_W-1:0] op_q;
   logic [W-1:0]     pc_q;
   dec_t             dec;
   logic [W-1:0]     rs_dat, rb_dat, r0_dat, addr, upd_val, ld_ext, wa_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         op_q <= '0;
         pc_q <= '0;
      end else if (op_valid && op_ready) begin
         busy <= 1'b1;
         op_q <= op_code;
         pc_q <= op_pc;
      end else if (finish) begin
         busy <= 1'b0;
      end
   end

   dm_decode i_dec (.opc(op_q), .dec(dec));

   dm_agen #(.W(W), .PC_STEP(PC_STEP)) i_agen (
      .dec(dec), .pc(pc_q), .base_reg(rb_dat), .idx_reg(r0_dat),
      .addr(addr), .upd_val(upd_val)
   );

   always_comb begin
      case (dec.size)
         SZ_B:    ld_ext = {{(W-8){mem_rdata[7]}},   mem_rdata[7:0]};
         SZ_W:    ld_ext = {{(W-16){mem_rdata[15]}}, mem_rdata[15:0]};
         default: ld_ext = mem_rdata;
      endcase
      case (dec.wsrc)
         WS_IMM:  wa_dat = {{(W-8){dec.imm[7]}}, dec.imm};
         WS_REG:  wa_dat = rs_dat;
         default: wa_dat = ld_ext;
      endcase
   end

   assign op_ready   = !busy;
   assign mem_req    = busy && dec.legal && dec.mem;
   assign finish     = busy && (!mem_req || mem_rsp);
   assign op_done    = finish;
   assign op_illegal = busy && !dec.legal;
   assign mem_we     = dec.store;
   assign mem_size   = dec.size;
   assign mem_addr   = addr;
   assign mem_wdata  = rs_dat;

   dm_regfile #(.W(W), .NREG(NREG), .CLEAR(CLEAR_REGS)) i_rf (
      .clk(clk), .rst_n(rst_n),
      .wa_en(finish && dec.legal && dec.wr_rd), .wa_idx(dec.rd), .wa_dat(wa_dat),
      .wb_en(finish && dec.legal && dec.upd != UP_NONE), .wb_idx(dec.rb), .wb_dat(upd_val),
      .ra_idx(dec.rs), .ra_dat(rs_dat),
      .rb_idx(dec.rb), .rb_dat(rb_dat),
      .r0_dat(r0_dat)
   );
endmodule

// File: rtl/dm_exec_chk.sv
module dm_exec_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic         op_ready,
   input logic         op_done,
   input logic         op_illegal,
   input logic         mem_req,
   input logic         mem_we,
   input logic [1:0]   mem_size,
   input logic [W-1:0] mem_addr,
   input logic         mem_rsp
);
   assert_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ready |=> !op_ready);

   assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> op_ready);

   assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !op_ready);

   assert_size_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_size != 2'b11);

   assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_illegal |-> op_done && !mem_req);

   assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we));

   assert_reset_idle_R13: assert property (@(posedge clk)
      !rst_n |=> op_ready && !mem_req);
endmodule

bind dm_exec dm_exec_chk #(.W(W)) i_chk (.*);

// File: tb/test_dm_exec.sv
module test_dm_exec;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] op;
      logic [31:0] pc;
      logic        mem;
      logic        we;
      logic [1:0]  sz;
      logic [31:0] addr;
      logic [31:0] wd;
      logic [31:0] rd;
      logic        ill;
      logic [1:0]  lat;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 48;
   // columns: op, pc, mem, we, size, addr, wdata, rdata, illegal, latency, requirement
   localparam vec_t TBL [NV] = '{
      '{16'h2352, 32'h0,    1,1,2'd2, 32'h0,        32'h0,        32'h0,        0,2'd1,4'd13}, // R13 regs zero
      '{16'hE17F, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd2},  // R2
      '{16'hE280, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd2},  // R2
      '{16'h2122, 32'h0,    1,1,2'd2, 32'h7F,       32'hFFFFFF80, 32'h0,        0,2'd0,4'd4},  // R4
      '{16'h6323, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd3},  // R3
      '{16'h2130, 32'h0,    1,1,2'd0, 32'h7F,       32'hFFFFFF80, 32'h0,        0,2'd2,4'd3},  // R3
      '{16'h6410, 32'h0,    1,0,2'd0, 32'h7F,       32'h0,        32'hAAAABB90, 0,2'd1,4'd4},  // R4
      '{16'h6511, 32'h0,    1,0,2'd1, 32'h7F,       32'h0,        32'h11117FFE, 0,2'd0,4'd4},  // R4
      '{16'h6612, 32'h0,    1,0,2'd2, 32'h7F,       32'h0,        32'h80000001, 0,2'd3,4'd4},  // R4
      '{16'h2542, 32'h0,    1,1,2'd2, 32'h7FFE,     32'hFFFFFF90, 32'h0,        0,2'd0,4'd4},  // R4
      '{16'h2662, 32'h0,    1,1,2'd2, 32'h80000001, 32'h80000001, 32'h0,        0,2'd0,4'd4},  // R4
      '{16'hE740, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd2},  // R2
      '{16'h2756, 32'h0,    1,1,2'd2, 32'h3C,       32'h7FFE,     32'h0,        0,2'd1,4'd5},  // R5
      '{16'h2745, 32'h0,    1,1,2'd1, 32'h3A,       32'hFFFFFF90, 32'h0,        0,2'd0,4'd5},  // R5
      '{16'h2774, 32'h0,    1,1,2'd0, 32'h39,       32'h3A,       32'h0,        0,2'd0,4'd5},  // R5 same reg
      '{16'h2172, 32'h0,    1,1,2'd2, 32'h7F,       32'h39,       32'h0,        0,2'd0,4'd5},  // R5
      '{16'hE820, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd2},  // R2
      '{16'h6984, 32'h0,    1,0,2'd0, 32'h20,       32'h0,        32'h00000081, 0,2'd2,4'd6},  // R6
      '{16'h6A85, 32'h0,    1,0,2'd1, 32'h21,       32'h0,        32'h00001234, 0,2'd0,4'd6},  // R6
      '{16'h6B86, 32'h0,    1,0,2'd2, 32'h23,       32'h0,        32'hCAFEF00D, 0,2'd1,4'd6},  // R6
      '{16'h2982, 32'h0,    1,1,2'd2, 32'hFFFFFF81, 32'h27,       32'h0,        0,2'd0,4'd6},  // R6
      '{16'h2BA2, 32'h0,    1,1,2'd2, 32'hCAFEF00D, 32'h1234,     32'h0,        0,2'd0,4'd6},  // R6
      '{16'h6886, 32'h0,    1,0,2'd2, 32'h27,       32'h0,        32'h00000500, 0,2'd0,4'd6},  // R6 same reg
      '{16'h2882, 32'h0,    1,1,2'd2, 32'h500,      32'h500,      32'h0,        0,2'd0,4'd6},  // R6
      '{16'hE010, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        0,2'd0,4'd2},  // R2
      '{16'h8085, 32'h0,    1,1,2'd0, 32'h505,      32'h10,       32'h0,        0,2'd0,4'd7},  // R7
      '{16'h8117, 32'h0,    1,1,2'd1, 32'h8D,       32'h10,       32'h0,        0,2'd1,4'd7},  // R7
      '{16'h8483, 32'h0,    1,0,2'd0, 32'h503,      32'h0,        32'h000000F0, 0,2'd0,4'd7},  // R7
      '{16'h8512, 32'h0,    1,0,2'd1, 32'h83,       32'h0,        32'h00008001, 0,2'd2,4'd7},  // R7
      '{16'h2102, 32'h0,    1,1,2'd2, 32'h7F,       32'hFFFF8001, 32'h0,        0,2'd0,4'd7},  // R7
      '{16'h18A3, 32'h0,    1,1,2'd2, 32'h50C,      32'h1234,     32'h0,        0,2'd0,4'd8},  // R8
      '{16'h5C8F, 32'h0,    1,0,2'd2, 32'h53C,      32'h0,        32'h13579BDF, 0,2'd1,4'd8},  // R8
      '{16'h21C2, 32'h0,    1,1,2'd2, 32'h7F,       32'h13579BDF, 32'h0,        0,2'd0,4'd8},  // R8
      '{16'h08A4, 32'h0,    1,1,2'd0, 32'hFFFF8501, 32'h1234,     32'h0,        0,2'd0,4'd9},  // R9
      '{16'h9D05, 32'h1002, 1,0,2'd1, 32'h1010,     32'h0,        32'h00008000, 0,2'd0,4'd10}, // R10
      '{16'hDE03, 32'h1002, 1,0,2'd2, 32'h1010,     32'h0,        32'h76543210, 0,2'd2,4'd10}, // R10
      '{16'h2ED2, 32'h0,    1,1,2'd2, 32'h76543210, 32'hFFFF8000, 32'h0,        0,2'd0,4'd10}, // R10
      '{16'h9F05, 32'h2001, 1,0,2'd1, 32'h200F,     32'h0,        32'h0000FFFF, 0,2'd0,4'd10}, // R10
      '{16'h2FF2, 32'h0,    1,1,2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        0,2'd0,4'd10}, // R10
      '{16'hDF01, 32'h2003, 1,0,2'd2, 32'h2008,     32'h0,        32'h00002222, 0,2'd0,4'd10}, // R10
      '{16'h2FF2, 32'h0,    1,1,2'd2, 32'h2222,     32'h2222,     32'h0,        0,2'd0,4'd10}, // R10
      '{16'h6017, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h2058, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h3000, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h0805, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h8200, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h2823, 32'h0,    0,0,2'd0, 32'h0,        32'h0,        32'h0,        1,2'd0,4'd11}, // R11
      '{16'h2802, 32'h0,    1,1,2'd2, 32'h500,      32'hFFFF8001, 32'h0,        0,2'd0,4'd11}  // R11 regs intact
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [15:0] op_code = '0;
   logic [31:0] op_pc = '0;
   logic        mem_rsp = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        op_ready, op_done, op_illegal, mem_req, mem_we;
   logic [1:0]  mem_size;
   logic [31:0] mem_addr, mem_wdata;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dm_exec i_dm_exec (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_pc(op_pc), .op_done(op_done), .op_illegal(op_illegal),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata)
   );

   task automatic report;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   task automatic run_vec(input vec_t v, input bit poke);
      logic rdy, req, we, ill, done, stall;
      logic [1:0] sz;
      logic [31:0] ad, wd;
      bit ok;
      @(negedge clk);
      rdy = op_ready;
      op_valid = 1'b1; op_code = v.op; op_pc = v.pc;
      @(posedge clk); #1; op_valid = 1'b0;
      @(negedge clk);
      req = mem_req; we = mem_we; sz = mem_size; ad = mem_addr; wd = mem_wdata;
      done = op_done; ill = op_illegal; stall = 1'b0;
      if (req) begin
         for (int k = 0; k < int'(v.lat); k++) begin
            if (poke) begin op_valid = 1'b1; op_code = 16'hE9FF; end
            @(negedge clk);
            if (!mem_req || mem_addr != ad || op_ready || op_done) stall = 1'b1;
         end
         op_valid = 1'b0;
         mem_rsp = 1'b1; mem_rdata = v.rd; #1;
         done = op_done; ill = op_illegal;
         @(posedge clk); #1; mem_rsp = 1'b0; mem_rdata = '0;
      end else begin
         @(posedge clk);
      end
      ok = rdy && done && (ill == v.ill) && (req == v.mem) && !stall &&
           (!v.mem || (we == v.we && sz == v.sz && ad == v.addr && (!v.we || wd == v.wd)));
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d op=%h: got req=%b we=%b sz=%0d addr=%h wd=%h ill=%b done=%b rdy=%b stall=%b; expected req=%b we=%b sz=%0d addr=%h wd=%h ill=%b",
                  v.tag, v.op, req, we, sz, ad, wd, ill, done, rdy, stall,
                  v.mem, v.we, v.sz, v.addr, v.wd, v.ill);
      end
   endtask

   task automatic check_idle(input string tag);
      n_chk++;
      if (!(op_ready && !mem_req && !op_done)) begin
         n_bad++;
         $display("FAIL %s idle after reset: got ready=%b req=%b done=%b; expected 1 0 0",
                  tag, op_ready, mem_req, op_done);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish; expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R13");
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) run_vec(TBL[i], 1'b0);
      // R1 / R12: opcode offered while busy is ignored, request held over three wait cycles
      run_vec('{16'h6912, 32'h0, 1'b1, 1'b0, 2'd2, 32'h7F, 32'h0, 32'h00000ABC, 1'b0, 2'd3, 4'd12}, 1'b1);
      run_vec('{16'h2192, 32'h0, 1'b1, 1'b1, 2'd2, 32'h7F, 32'h00000ABC, 32'h0, 1'b0, 2'd0, 4'd1}, 1'b0);
      // R13: second reset clears the registers again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check_idle("R13");
      rst_n = 1'b1;
      run_vec('{16'h2192, 32'h0, 1'b1, 1'b1, 2'd2, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd13}, 1'b0);
      report();
   end
endmodule